// File: doc/BRIEF.md
# Conditional-Execution State Tracker

This block holds the 8-bit conditional-execution state that a compact-instruction front-end predecoder consults for each fetched instruction. The state is split into a 4-bit condition nibble (bits 7:4) and a 4-bit mask nibble (bits 3:0). An ordinary control-flow redirect throws the state away. A redirect that also rewrites the status register, such as an exception return or a status-register move, carries a recovered state taken from the new status word. The predecoder can then use that state before the status-register write reaches commit.

A recovered state is held but marked invalid until the next PC advance. That advance makes it valid, and later advances step it with the ordinary conditional-block rule until the mask runs out. The block is a four-state machine:
- `ST_IDLE`: no state; zero and invalid.
- `ST_PEND`: recovered state held, still invalid.
- `ST_LIVE`: recovered state in force for its first instruction.
- `ST_BLOCK`: state stepped at least once inside a conditional block.

Transitions:
- Any state goes to `ST_PEND` on a status-writing redirect, and to `ST_IDLE` on a plain redirect.
- `ST_PEND` goes to `ST_LIVE` on an advance.
- `ST_LIVE` and `ST_BLOCK` go to `ST_BLOCK` on an advance with mask bits 2:0 not zero, and to `ST_IDLE` on an advance with those bits zero.
- `ST_IDLE` stays where it is on an advance.

Top module: `itk_tracker`

## Requirements
- R1: After reset, cond_o and mask_o are 0 and valid_o is low.
- R2: A redirect with redir_sr_i low sets cond_o and mask_o to 0 and valid_o low on the next clock.
- R3: A redirect with redir_sr_i high loads the state {sr_it_hi_i, sr_it_lo_i}: sr_it_hi_i fills bits 7:2 and sr_it_lo_i fills bits 1:0. cond_o shows bits 7:4 and mask_o shows bits 3:0, and valid_o is low, on the next clock.
- R4: The recovered state is captured at the redirect. Later changes on sr_it_hi_i or sr_it_lo_i without a status-writing redirect do not alter cond_o or mask_o.
- R5: The first advance after a status-writing redirect raises valid_o and leaves cond_o and mask_o unchanged.
- R6: While valid_o is high, an advance with mask_o[2:0] not zero keeps state bits 7:5 and shifts bits 4:0 left by one, inserting 0. valid_o stays high.
- R7: While valid_o is high, an advance with mask_o[2:0] equal to zero clears cond_o and mask_o to 0 and drops valid_o.
- R8: When a redirect and an advance arrive in the same cycle, the redirect alone takes effect.
- R9: In a cycle with neither advance nor redirect, cond_o, mask_o and valid_o hold.
- R10: An advance in the idle state (zero and invalid, no recovery pending) leaves the outputs at 0 and invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| adv_i | input | 1 | PC-advance strobe |
| redir_i | input | 1 | Control-flow redirect strobe |
| redir_sr_i | input | 1 | Redirect also writes the status register |
| sr_it_hi_i | input | 6 | Upper conditional-state field of the new status word |
| sr_it_lo_i | input | 2 | Lower conditional-state field of the new status word |
| cond_o | output | 4 | Current condition nibble (state bits 7:4) |
| mask_o | output | 4 | Current mask nibble (state bits 3:0) |
| valid_o | output | 1 | Current state is usable by the predecoder |

## Verification
The bench walks an exception return whose recovered mask is already exhausted. It checks three points: the state is invalid right after the redirect, valid after one advance, and zero after the second. A design that validated on the redirect, or kept the state for a second instruction, fails there. A longer recovered block is stepped through every shift, so a wrong fill bit or a wrong termination test gives a wrong nibble. Same-cycle redirect and advance pairs catch a design that lets the advance win. Changing the status fields after a recovery catches a design that reads the fields live instead of capturing them.

// File: rtl/itk_pkg.sv
package itk_pkg;

    localparam int unsigned ITK_W    = 8;
    localparam int unsigned ITK_LO_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PEND  = 2'd1,
        ST_LIVE  = 2'd2,
        ST_BLOCK = 2'd3
    } itk_state_e;

endpackage

// File: rtl/itk_pack.sv
module itk_pack #(
    parameter int unsigned IT_W = 8,
    parameter int unsigned LO_W = 2,
    localparam int unsigned HI_W = IT_W - LO_W
) (
    input  logic [HI_W-1:0] hi_i,
    input  logic [LO_W-1:0] lo_i,
    output logic [IT_W-1:0] it_o
);
    // Upper field fills the top bits, lower field the bottom bits.
    assign it_o = {hi_i, lo_i};
endmodule

// File: rtl/itk_step.sv
module itk_step #(
    parameter int unsigned IT_W = 8,
    localparam int unsigned TAIL_W = 3,
    localparam int unsigned SHF_W  = IT_W - TAIL_W
) (
    input  logic [IT_W-1:0] cur_i,
    output logic [IT_W-1:0] nxt_o,
    output logic            done_o
);
    // The block ends when the low mask bits hold no further instruction.
    assign done_o = (cur_i[TAIL_W-1:0] == '0);

    always_comb begin
        if (done_o) begin
            nxt_o = '0;
        end else begin
            nxt_o = {cur_i[IT_W-1:SHF_W], cur_i[SHF_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/itk_tracker.sv
module itk_tracker
    import itk_pkg::*;
#(
    parameter int unsigned IT_W = itk_pkg::ITK_W,
    parameter int unsigned LO_W = itk_pkg::ITK_LO_W,
    localparam int unsigned HI_W = IT_W - LO_W,
    localparam int unsigned NIB_W = IT_W / 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            adv_i,
    input  logic            redir_i,
    input  logic            redir_sr_i,
    input  logic [HI_W-1:0] sr_it_hi_i,
    input  logic [LO_W-1:0] sr_it_lo_i,
    output logic [NIB_W-1:0] cond_o,
    output logic [NIB_W-1:0] mask_o,
    output logic            valid_o
);

    itk_state_e      state_q, state_d;
    logic [IT_W-1:0] it_q, it_d;
    logic [IT_W-1:0] forced_it;
    logic [IT_W-1:0] step_it;
    logic            step_done;

    itk_pack #(.IT_W(IT_W), .LO_W(LO_W)) u_pack (
        .hi_i (sr_it_hi_i),
        .lo_i (sr_it_lo_i),
        .it_o (forced_it)
    );

    itk_step #(.IT_W(IT_W)) u_step (
        .cur_i  (it_q),
        .nxt_o  (step_it),
        .done_o (step_done)
    );

    // Next state and next value; a redirect takes precedence over an advance.
    always_comb begin
        state_d = state_q;
        it_d    = it_q;
        if (redir_i) begin
            if (redir_sr_i) begin
                state_d = ST_PEND;
                it_d    = forced_it;
            end else begin
                state_d = ST_IDLE;
                it_d    = '0;
            end
        end else if (adv_i) begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                    it_d    = '0;
                end
                ST_PEND: begin
                    state_d = ST_LIVE;
                end
                ST_LIVE, ST_BLOCK: begin
                    if (step_done) begin
                        state_d = ST_IDLE;
                        it_d    = '0;
                    end else begin
                        state_d = ST_BLOCK;
                        it_d    = step_it;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    it_d    = '0;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            it_q    <= '0;
        end else begin
            state_q <= state_d;
            it_q    <= it_d;
        end
    end

    // Outputs.
    always_comb begin
        cond_o  = it_q[IT_W-1:NIB_W];
        mask_o  = it_q[NIB_W-1:0];
        valid_o = (state_q == ST_LIVE) || (state_q == ST_BLOCK);
    end

endmodule

// File: rtl/itk_tracker_chk.sv
module itk_tracker_chk #(
    parameter int unsigned HI_W  = 6,
    parameter int unsigned LO_W  = 2,
    parameter int unsigned NIB_W = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             adv_i,
    input logic             redir_i,
    input logic             redir_sr_i,
    input logic [HI_W-1:0]  sr_it_hi_i,
    input logic [LO_W-1:0]  sr_it_lo_i,
    input logic [NIB_W-1:0] cond_o,
    input logic [NIB_W-1:0] mask_o,
    input logic             valid_o
);

    // R2 and R8: a plain redirect clears, whatever the advance strobe does.
    a_r2_plain_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (redir_i && !redir_sr_i) |=> (cond_o == '0 && mask_o == '0 && !valid_o));

    // R3 and R8: a status-writing redirect loads the packed fields, invalid.
    a_r3_forced_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (redir_i && redir_sr_i) |=>
        ({cond_o, mask_o} == {$past(sr_it_hi_i), $past(sr_it_lo_i)} && !valid_o));

    // R5: the advance right after a recovery validates without changing the value.
    a_r5_validate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && !redir_i && $past(redir_i && redir_sr_i)) |=>
        (valid_o && $stable(cond_o) && $stable(mask_o)));

    // R6: a valid advance with mask bits left shifts the state.
    a_r6_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && adv_i && !redir_i && mask_o[2:0] != '0) |=>
        (valid_o && cond_o == {$past(cond_o[3:1]), $past(mask_o[3])}
                 && mask_o == {$past(mask_o[2:0]), 1'b0}));

    // R7: a valid advance on an exhausted mask clears and invalidates.
    a_r7_exhaust: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && adv_i && !redir_i && mask_o[2:0] == '0) |=>
        (cond_o == '0 && mask_o == '0 && !valid_o));

    // R9: no strobe, no change.
    a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!adv_i && !redir_i) |=>
        ($stable(cond_o) && $stable(mask_o) && $stable(valid_o)));

endmodule

bind itk_tracker itk_tracker_chk #(
    .HI_W  (HI_W),
    .LO_W  (LO_W),
    .NIB_W (NIB_W)
) u_itk_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv_i),
    .redir_i    (redir_i),
    .redir_sr_i (redir_sr_i),
    .sr_it_hi_i (sr_it_hi_i),
    .sr_it_lo_i (sr_it_lo_i),
    .cond_o     (cond_o),
    .mask_o     (mask_o),
    .valid_o    (valid_o)
);

// File: tb/test_itk_tracker.sv
module test_itk_tracker;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       adv_i = 1'b0;
    logic       redir_i = 1'b0;
    logic       redir_sr_i = 1'b0;
    logic [5:0] sr_it_hi_i = '0;
    logic [1:0] sr_it_lo_i = '0;
    logic [3:0] cond_o;
    logic [3:0] mask_o;
    logic       valid_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk_i = ~clk_i;

    itk_tracker i_itk_tracker (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .adv_i      (adv_i),
        .redir_i    (redir_i),
        .redir_sr_i (redir_sr_i),
        .sr_it_hi_i (sr_it_hi_i),
        .sr_it_lo_i (sr_it_lo_i),
        .cond_o     (cond_o),
        .mask_o     (mask_o),
        .valid_o    (valid_o)
    );

    task automatic expect_out(input string tag, input logic [3:0] ec,
                              input logic [3:0] em, input logic ev);
        checks++;
        if (cond_o !== ec || mask_o !== em || valid_o !== ev) begin
            failures++;
            $display("FAIL %s: got cond=%h mask=%h valid=%b, expected cond=%h mask=%h valid=%b",
                     tag, cond_o, mask_o, valid_o, ec, em, ev);
        end
    endtask

    // One clock with the given strobes; outputs are sampled at the following negedge.
    task automatic cycle(input logic adv, input logic redir, input logic wr,
                         input logic [7:0] it);
        @(negedge clk_i);
        adv_i      = adv;
        redir_i    = redir;
        redir_sr_i = wr;
        sr_it_hi_i = it[7:2];
        sr_it_lo_i = it[1:0];
        @(negedge clk_i);
        adv_i      = 1'b0;
        redir_i    = 1'b0;
        redir_sr_i = 1'b0;
    endtask

    task automatic t_reset;
        rst_ni = 1'b0;
        repeat (3) @(negedge clk_i);
        expect_out("R1 reset", 4'h0, 4'h0, 1'b0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        expect_out("R1 after release", 4'h0, 4'h0, 1'b0);
    endtask

    task automatic t_idle_advance;
        cycle(1'b1, 1'b0, 1'b0, 8'hFF);
        expect_out("R10 idle advance", 4'h0, 4'h0, 1'b0);
    endtask

    task automatic t_exc_return;
        cycle(1'b0, 1'b1, 1'b1, 8'h18);
        expect_out("R3 exception return load", 4'h1, 4'h8, 1'b0);
        cycle(1'b0, 1'b0, 1'b0, 8'h00);
        expect_out("R9 hold while pending", 4'h1, 4'h8, 1'b0);
        cycle(1'b1, 1'b0, 1'b0, 8'h00);
        expect_out("R5 first advance validates", 4'h1, 4'h8, 1'b1);
        cycle(1'b1, 1'b0, 1'b0, 8'h00);
        expect_out("R7 exhausted mask clears", 4'h0, 4'h0, 1'b0);
    endtask

    task automatic t_block_walk;
        cycle(1'b0, 1'b1, 1'b1, 8'hA6);
        expect_out("R3 load A6", 4'hA, 4'h6, 1'b0);
        cycle(1'b0, 1'b0, 1'b0, 8'h3D);
        expect_out("R4 later status fields ignored", 4'hA, 4'h6, 1'b0);
        cycle(1'b1, 1'b0, 1'b0, 8'h00);
        expect_out("R5 validate A6", 4'hA, 4'h6, 1'b1);
        cycle(1'b1, 1'b0, 1'b0, 8'h00);
        expect_out("R6 shift to AC", 4'hA, 4'hC, 1'b1);
        cycle(1'b0, 1'b0, 1'b0, 8'h00);
        expect_out("R9 hold in block", 4'hA, 4'hC, 1'b1);
        cycle(1'b1, 1'b0, 1'b0, 8'h00);
        expect_out("R6 shift to B8", 4'hB, 4'h8, 1'b1);
        cycle(1'b1, 1'b0, 1'b0, 8'h00);
        expect_out("R7 end of block", 4'h0, 4'h0, 1'b0);
    endtask

    task automatic t_plain_redirect;
        cycle(1'b0, 1'b1, 1'b1, 8'h57);
        cycle(1'b1, 1'b0, 1'b0, 8'h00);
        expect_out("R5 validate 57", 4'h5, 4'h7, 1'b1);
        cycle(1'b0, 1'b1, 1'b0, 8'hFF);
        expect_out("R2 plain redirect clears", 4'h0, 4'h0, 1'b0);
    endtask

    task automatic t_priority;
        cycle(1'b0, 1'b1, 1'b1, 8'h57);
        cycle(1'b1, 1'b0, 1'b0, 8'h00);
        cycle(1'b1, 1'b1, 1'b0, 8'h00);
        expect_out("R8 plain redirect beats advance", 4'h0, 4'h0, 1'b0);
        cycle(1'b0, 1'b1, 1'b1, 8'h57);
        cycle(1'b1, 1'b0, 1'b0, 8'h00);
        cycle(1'b1, 1'b1, 1'b1, 8'h2C);
        expect_out("R8 forced redirect beats advance", 4'h2, 4'hC, 1'b0);
        cycle(1'b1, 1'b1, 1'b1, 8'h9E);
        expect_out("R8 reload while pending", 4'h9, 4'hE, 1'b0);
        cycle(1'b1, 1'b0, 1'b0, 8'h00);
        expect_out("R5 validate 9E", 4'h9, 4'hE, 1'b1);
        cycle(1'b1, 1'b0, 1'b0, 8'h00);
        expect_out("R6 shift 9E to 9C", 4'h9, 4'hC, 1'b1);
    endtask

    initial begin
        t_reset();
        t_idle_advance();
        t_exc_return();
        t_block_walk();
        t_plain_redirect();
        t_priority();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int n = 0; n < 20000; n++) begin
            @(posedge clk_i);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule